// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the general-purpose and status registers of a small 32-bit processor core that runs in one of several operating modes. Software always sees sixteen logical registers, numbered 0 to 15, plus a current status word and a saved status word. Behind those names sit 37 physical registers. Registers 0 to 7 and the program counter (logical 15) are the same storage in every mode. The fast-interrupt mode has private copies of registers 8 to 14. Every other privileged mode has private copies of registers 13 (stack pointer) and 14 (return address). Each privileged mode also has its own saved status register.

The core drives two combinational read ports and one synchronous write port, each addressed by a 4-bit logical number. The block translates every logical number to a physical one using the current mode. The current mode is held in bits [2:0] of the current status word.

A mode-entry strobe stores the current status word in the target mode's saved status register and switches to the target mode, both on the same clock edge. A return strobe copies the current mode's saved status word back into the current status word, which also restores the previous mode. Instruction decode, exception priority and the ALU belong to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears all general registers and every saved status register to zero, and sets the current status word to 4, which selects supervisor mode.
- R2: Mode codes are user 0, system 1, fast-interrupt 2, interrupt 3, supervisor 4, abort 5 and undefined 6, taken from status bits [2:0]. Logical registers 0 to 7 reach the same storage in every mode.
- R3: In fast-interrupt mode, logical registers 8 to 12 reach storage that is private to that mode. In every other mode they reach one shared set.
- R4: Logical registers 13 and 14 are private to each of fast-interrupt, interrupt, supervisor, abort and undefined. User and system share one copy.
- R5: Logical register 15 is a single program-counter register, shared by all modes.
- R6: A write takes effect at the clock edge. A read of the same register in the same cycle returns the old value.
- R7: On the mode-entry strobe, the target mode's saved status register receives the current status word, and the mode field becomes the target mode, at one edge. Entering user or system mode only changes the mode.
- R8: On the return strobe in a privileged mode, the current status word is loaded from that mode's saved status register. In user or system mode the return strobe is ignored.
- R9: In user or system mode the saved status output reads zero, and a write to the saved status register changes no stored value.
- R10: When strobes coincide, mode entry wins over return, and return wins over a status write. Writes of the status words select the word by sel (0 current, 1 saved).
- R11: The two read ports are independent and may address any two registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | 32 | Write data |
| enter_en | input | 1 | Mode-entry strobe |
| enter_mode | input | 3 | Target mode for mode entry |
| ret_en | input | 1 | Return strobe (restore status) |
| sr_we | input | 1 | Status word write enable |
| sr_sel | input | 1 | Status word select: 0 current, 1 saved |
| sr_wdata | input | 32 | Status word write data |
| status_cur | output | 32 | Current status word |
| status_saved | output | 32 | Saved status word of the current mode |
| mode_cur | output | 3 | Current mode code |

## Verification
A wrong bank mapping shows up as a different value at a read port once the mode changes. This happens the first time a banked register is read after a write in another mode, so the bench writes the same logical numbers in many modes and then reads every one back in every mode. A wrong status save or restore shows at status_cur, status_saved or mode_cur one edge after the strobe. The bench checks these edges directly, including coinciding strobes and strobes issued in modes without a saved status register.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;
  localparam int MODE_W    = 3;
  localparam int LOG_N     = 16;
  localparam int LOG_W     = $clog2(LOG_N);
  localparam int SAVED_N   = 5;
  localparam int SLOT_W    = $clog2(SAVED_N);

  typedef enum logic [MODE_W-1:0] {
    MD_USR = 3'd0,
    MD_SYS = 3'd1,
    MD_FIQ = 3'd2,
    MD_IRQ = 3'd3,
    MD_SVC = 3'd4,
    MD_ABT = 3'd5,
    MD_UND = 3'd6
  } mode_e;

  typedef struct packed {
    logic              ok;
    logic [SLOT_W-1:0] slot;
  } slot_t;

  // Saved-status slot of a mode; user, system and code 7 have none.
  function automatic slot_t saved_slot(input logic [MODE_W-1:0] m);
    slot_t s;
    s.ok   = (m >= MD_FIQ) && (m <= MD_UND);
    s.slot = s.ok ? SLOT_W'(m - MD_FIQ) : '0;
    return s;
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import banked_regfile_pkg::*;
#(
  parameter int PHYS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [LOG_W-1:0]  log_idx,
  output logic [PHYS_W-1:0] phys_idx
);
  // Physical layout: 0..15 shared view, 16..22 fast-interrupt 8..14,
  // then pairs for 13/14 of irq, svc, abt, und.
  localparam int FIQ_BASE  = LOG_N;
  localparam int PAIR_BASE = FIQ_BASE + 7;

  always_comb begin
    phys_idx = PHYS_W'(log_idx);
    if (log_idx >= 4'd8 && log_idx <= 4'd14 && mode == MD_FIQ) begin
      phys_idx = PHYS_W'(FIQ_BASE + int'(log_idx) - 8);
    end else if (log_idx >= 4'd13 && log_idx <= 4'd14 &&
                 mode >= MD_IRQ && mode <= MD_UND) begin
      phys_idx = PHYS_W'(PAIR_BASE + 2 * (int'(mode) - int'(MD_IRQ))
                         + int'(log_idx) - 13);
    end
  end

  // R2 / R5: low registers and the program counter never leave the shared view
  p_shared_view_r2: assert property (@(posedge clk) disable iff (rst)
    (log_idx < 4'd8 || log_idx == 4'd15) |-> phys_idx == PHYS_W'(log_idx));

  // R3: fast-interrupt mode reaches only its private block for 8..14
  p_fiq_private_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_FIQ && log_idx >= 4'd8 && log_idx <= 4'd14)
      |-> phys_idx >= PHYS_W'(FIQ_BASE) && phys_idx < PHYS_W'(PAIR_BASE));
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     ra_addr,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  // R6: a write is visible in the addressed cell after the edge
  p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/status_unit.sv
module status_unit
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_en,
  input  logic [MODE_W-1:0] enter_mode,
  input  logic              ret_en,
  input  logic              sr_we,
  input  logic              sr_sel,
  input  logic [DATA_W-1:0] sr_wdata,
  output logic [DATA_W-1:0] cur_o,
  output logic [DATA_W-1:0] saved_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam logic [DATA_W-1:0] CUR_RESET = DATA_W'(MD_SVC);

  logic [DATA_W-1:0]              cur_q;
  logic [SAVED_N-1:0][DATA_W-1:0] saved_q;
  slot_t cur_s, tgt_s;

  assign mode_o = cur_q[MODE_W-1:0];
  assign cur_s  = saved_slot(mode_o);
  assign tgt_s  = saved_slot(enter_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= CUR_RESET;
      saved_q <= '0;
    end else if (enter_en) begin
      cur_q[MODE_W-1:0] <= enter_mode;
      if (tgt_s.ok) saved_q[tgt_s.slot] <= cur_q;
    end else if (ret_en) begin
      if (cur_s.ok) cur_q <= saved_q[cur_s.slot];
    end else if (sr_we) begin
      if (!sr_sel)        cur_q <= sr_wdata;
      else if (cur_s.ok)  saved_q[cur_s.slot] <= sr_wdata;
    end
  end

  assign cur_o   = cur_q;
  assign saved_o = cur_s.ok ? saved_q[cur_s.slot] : '0;

  // R7: entry switches the mode at the next edge
  p_enter_mode_r7: assert property (@(posedge clk) disable iff (rst)
    enter_en |=> mode_o == $past(enter_mode));

  // R7: entry saves the old status word into the target slot
  p_enter_save_r7: assert property (@(posedge clk) disable iff (rst)
    (enter_en && tgt_s.ok) |=> saved_q[$past(tgt_s.slot)] == $past(cur_q));

  // R8: return restores from the current mode's saved word
  p_ret_restore_r8: assert property (@(posedge clk) disable iff (rst)
    (!enter_en && ret_en && cur_s.ok) |=> cur_q == $past(saved_o));

  // R8: return without a saved word leaves status alone
  p_ret_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (!enter_en && ret_en && !cur_s.ok) |=> $stable(cur_q));

  // R9: saved-word write in user/system touches no slot
  p_saved_guard_r9: assert property (@(posedge clk) disable iff (rst)
    (!enter_en && !ret_en && sr_we && sr_sel && !cur_s.ok) |=> $stable(saved_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PHYS_N = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              enter_en,
  input  logic [2:0]        enter_mode,
  input  logic              ret_en,
  input  logic              sr_we,
  input  logic              sr_sel,
  input  logic [DATA_W-1:0] sr_wdata,
  output logic [DATA_W-1:0] status_cur,
  output logic [DATA_W-1:0] status_saved,
  output logic [2:0]        mode_cur
);
  localparam int PHYS_W = $clog2(PHYS_N);
  localparam int PORTS  = 3;

  logic [LOG_W-1:0]  log_idx  [PORTS];
  logic [PHYS_W-1:0] phys_idx [PORTS];
  logic [MODE_W-1:0] mode_w;

  assign log_idx[0] = rd_a_idx;
  assign log_idx[1] = rd_b_idx;
  assign log_idx[2] = wr_idx;

  for (genvar p = 0; p < PORTS; p++) begin : g_map
    bank_map #(.PHYS_W(PHYS_W)) u_map (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode_w),
      .log_idx  (log_idx[p]),
      .phys_idx (phys_idx[p])
    );
  end

  gpr_store #(.DATA_W(DATA_W), .DEPTH(PHYS_N), .AW(PHYS_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (phys_idx[2]),
    .wr_data (wr_data),
    .ra_addr (phys_idx[0]),
    .rb_addr (phys_idx[1]),
    .ra_data (rd_a_data),
    .rb_data (rd_b_data)
  );

  status_unit #(.DATA_W(DATA_W)) u_status (
    .clk        (clk),
    .rst        (rst),
    .enter_en   (enter_en),
    .enter_mode (enter_mode),
    .ret_en     (ret_en),
    .sr_we      (sr_we),
    .sr_sel     (sr_sel),
    .sr_wdata   (sr_wdata),
    .cur_o      (status_cur),
    .saved_o    (status_saved),
    .mode_o     (mode_w)
  );

  assign mode_cur = mode_w;

  // R10: entry beats return and status write
  p_enter_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (enter_en && (ret_en || sr_we)) |=> mode_cur == $past(enter_mode));
endmodule

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sr_wdata = '0;
  logic        wr_en = 1'b0, enter_en = 1'b0, ret_en = 1'b0, sr_we = 1'b0, sr_sel = 1'b0;
  logic [2:0]  enter_mode = '0, mode_cur;
  logic [31:0] status_cur, status_saved;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] mdl [0:1023];

  always #4 clk = ~clk;

  banked_regfile dut_i (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .enter_en(enter_en), .enter_mode(enter_mode), .ret_en(ret_en),
    .sr_we(sr_we), .sr_sel(sr_sel), .sr_wdata(sr_wdata),
    .status_cur(status_cur), .status_saved(status_saved), .mode_cur(mode_cur)
  );

  // {mode, logical index, data}
  localparam logic [38:0] VEC [16] = '{
    {3'd0, 4'd0,  32'h0000_0011}, {3'd0, 4'd8,  32'h0000_00A8},
    {3'd2, 4'd8,  32'h0000_00F8}, {3'd2, 4'd13, 32'h0000_00FD},
    {3'd3, 4'd13, 32'h0000_01D0}, {3'd4, 4'd14, 32'h0000_005E},
    {3'd5, 4'd13, 32'h0000_00AD}, {3'd6, 4'd14, 32'h0000_00EE},
    {3'd1, 4'd13, 32'h0000_00CD}, {3'd2, 4'd0,  32'h0000_00F0},
    {3'd3, 4'd15, 32'h0000_1000}, {3'd6, 4'd7,  32'h0000_0077},
    {3'd2, 4'd12, 32'h0000_00FC}, {3'd0, 4'd12, 32'h0000_000C},
    {3'd4, 4'd13, 32'h0000_005D}, {3'd5, 4'd14, 32'h0000_00AE}
  };

  // Owner of a (mode, register) pair, written from the requirements
  function automatic int owner(input int m, input int r);
    if (r < 8 || r == 15) return r;                        // R2, R5
    if (r < 13) return (m == 2) ? 200 + r : r;             // R3
    if (m >= 2 && m <= 6) return m * 100 + r;              // R4
    return r;
  endfunction

  function automatic string tag(input int r);
    if (r < 8)   return "R2";
    if (r < 13)  return "R3";
    if (r < 15)  return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic go_mode(input logic [2:0] m);
    @(negedge clk);
    enter_en = 1'b1; enter_mode = m;
    tick();
    enter_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mdl[i] = '0;
    repeat (2) tick();
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1 mode", {29'd0, mode_cur}, 32'd4);
    chk("R1 status", status_cur, 32'd4);
    chk("R1 saved", status_saved, 32'd0);
    rd_a_idx = 4'd13; rd_b_idx = 4'd15; #1;
    chk("R1 r13", rd_a_data, 32'd0);
    chk("R1 r15", rd_b_data, 32'd0);

    // Vector table: write each entry from its mode
    for (int v = 0; v < 16; v++) begin
      go_mode(VEC[v][38:36]);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = VEC[v][35:32]; wr_data = VEC[v][31:0];
      tick();
      wr_en = 1'b0;
      mdl[owner(int'(VEC[v][38:36]), int'(VEC[v][35:32]))] = VEC[v][31:0];
    end
    // Read every register in every mode on both ports (R11)
    for (int m = 0; m < 7; m++) begin
      go_mode(3'(m));
      for (int r = 0; r < 16; r++) begin
        @(negedge clk);
        rd_a_idx = 4'(r); rd_b_idx = 4'(15 - r); #1;
        chk(tag(r), rd_a_data, mdl[owner(m, r)]);
        chk({"R11 ", tag(15 - r)}, rd_b_data, mdl[owner(m, 15 - r)]);
      end
    end

    // R6: same-cycle read returns old value
    @(negedge clk);
    rst = 1'b1; tick(); @(negedge clk); rst = 1'b0;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_0003; rd_a_idx = 4'd3; #1;
    chk("R6 old", rd_a_data, 32'd0);
    tick(); wr_en = 1'b0;
    chk("R6 new", rd_a_data, 32'hDEAD_0003);

    // R7: entry saves status and switches mode
    @(negedge clk);
    sr_we = 1'b1; sr_sel = 1'b0; sr_wdata = 32'hABCD_0004;
    tick(); sr_we = 1'b0;
    go_mode(3'd3);
    chk("R7 mode", {29'd0, mode_cur}, 32'd3);
    chk("R7 status", status_cur, 32'hABCD_0003);
    chk("R7 saved", status_saved, 32'hABCD_0004);

    // R8: return restores
    @(negedge clk); ret_en = 1'b1; tick(); ret_en = 1'b0;
    chk("R8 restore", status_cur, 32'hABCD_0004);
    chk("R8 mode", {29'd0, mode_cur}, 32'd4);

    // R8/R9: user mode ignores return and saved writes
    go_mode(3'd0);
    chk("R9 saved zero", status_saved, 32'd0);
    @(negedge clk); ret_en = 1'b1; tick(); ret_en = 1'b0;
    chk("R8 ignored", status_cur, 32'hABCD_0000);
    @(negedge clk); sr_we = 1'b1; sr_sel = 1'b1; sr_wdata = 32'h0000_1234;
    tick(); sr_we = 1'b0;
    chk("R9 still zero", status_saved, 32'd0);
    @(negedge clk); sr_we = 1'b1; sr_sel = 1'b0; sr_wdata = 32'd2;
    tick(); sr_we = 1'b0;
    chk("R9 fiq slot", status_saved, 32'd0);
    @(negedge clk); sr_we = 1'b1; sr_sel = 1'b0; sr_wdata = 32'd3;
    tick(); sr_we = 1'b0;
    chk("R9 irq slot", status_saved, 32'hABCD_0004);

    // R10: entry beats return and status write
    @(negedge clk);
    enter_en = 1'b1; enter_mode = 3'd5; ret_en = 1'b1;
    sr_we = 1'b1; sr_sel = 1'b0; sr_wdata = 32'h5555_5556;
    tick();
    enter_en = 1'b0; ret_en = 1'b0; sr_we = 1'b0;
    chk("R10 mode", {29'd0, mode_cur}, 32'd5);
    chk("R10 saved", status_saved, 32'd3);
    chk("R10 status", status_cur, 32'd5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule